// File: doc/BRIEF.md
# Remanence Stable-Cell Enrollment Controller

This controller finds the most robust cells of a small test SRAM for use as physical-unclonable-function bits. It does not use repeated power-up voting. It runs two forced-value power interruptions instead. In the first pass every cell is written to '1'. A power-gate request is then held for a programmed number of milliseconds, which is long enough for only the weakest cells to lose their data. After power-good returns, the array is read back. The second pass does the same with every cell written to '0'.

A cell that gives way easily while holding one value is strongly biased toward the other value. So a cell that drops from '1' to '0' becomes a strong-'0' candidate, and a cell that rises from '0' to '1' becomes a strong-'1' candidate. Each polarity has its own off-time, because the two decay behaviours can need different durations. A cell that moves in both passes is not trusted. The search usually over-selects, so only the requested number of cells per polarity is kept, counting from address zero upward. The result is a pair of masks and a selected count per polarity, plus a flag that shows when a polarity came up short.

Top module: `remanence_enroll`

## Requirements
- R1: A start pulse accepted while idle or done begins a fill that writes '1' to every address, one per cycle in ascending order. The second fill writes '0' the same way. No other writes occur.
- R2: After each fill, pg_req is high for exactly off*PRESCALE+1 consecutive cycles. The off value is off_one_ms (latched at start) after the all-'1' fill and off_zero_ms after the all-'0' fill.
- R3: No memory access takes place while pg_req is high. After pg_req falls, no read is issued until pg_ack is high. Each pass then reads every address once.
- R4: A cell that reads '0' after the all-'1' pass is a strong-'0' candidate. A cell that reads '1' after the all-'0' pass is a strong-'1' candidate. Bit i of mask_zero and mask_one refers to address i.
- R5: A cell that changes in both passes is set in neither mask. The two masks never share a set bit.
- R6: For each polarity, only the lowest-addressed candidates are set in the mask, up to the want value latched at start.
- R7: done goes high when selection ends, with sel_one and sel_zero equal to the popcounts of the masks. It stays high until the next accepted start. A start pulse while busy has no effect on the run or its result. While done is high, there is no memory access and no power request.
- R8: shortfall is high with done exactly when sel_one < want or sel_zero < want.
- R9: After reset, done, busy, pg_req and mem_en are low and both masks are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an enrollment run (ignored while busy) |
| off_one_ms | input | MS_W | Off-time in ms after the all-'1' fill |
| off_zero_ms | input | MS_W | Off-time in ms after the all-'0' fill |
| want | input | CW | Requested cells per polarity |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | AW | Cell address |
| mem_wdata | output | 1 | Write data |
| mem_rdata | input | 1 | Read data, combinational from mem_addr |
| pg_req | output | 1 | Request to remove array power |
| pg_ack | input | 1 | Power-good from the supply switch |
| done | output | 1 | Results valid |
| busy | output | 1 | Run in progress |
| mask_one | output | N_CELLS | Selected strong-'1' cells |
| mask_zero | output | N_CELLS | Selected strong-'0' cells |
| sel_one | output | CW | Number of strong-'1' cells selected |
| sel_zero | output | CW | Number of strong-'0' cells selected |
| shortfall | output | 1 | A polarity has fewer than want cells |

## Verification
The hardest case to reach is a cell that decays in both directions. It only shows up when both off-times pass that cell's decay thresholds, and it has to land among the lowest addresses so that excluding it changes which cells fill the quota. The bench's behavioural array gives every cell its own decay time for each stored value, taken from a seeded formula. Table rows with long, equal off-times make many such doubles, and the bench checks every double cell against both masks. A slow power-good return and a start pulse issued in the middle of a power cut are driven as directed cases.

// File: rtl/remanence_enroll.sv
module remanence_enroll #(
  parameter int N_CELLS  = 32,
  parameter int PRESCALE = 100000,
  parameter int MS_W     = 10,
  localparam int AW = $clog2(N_CELLS),
  localparam int CW = $clog2(N_CELLS + 1),
  localparam int PW = $clog2(PRESCALE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MS_W-1:0]   off_one_ms,
  input  logic [MS_W-1:0]   off_zero_ms,
  input  logic [CW-1:0]     want,
  output logic              mem_en,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic              mem_wdata,
  input  logic              mem_rdata,
  output logic              pg_req,
  input  logic              pg_ack,
  output logic              done,
  output logic              busy,
  output logic [N_CELLS-1:0] mask_one,
  output logic [N_CELLS-1:0] mask_zero,
  output logic [CW-1:0]     sel_one,
  output logic [CW-1:0]     sel_zero,
  output logic              shortfall
);

  typedef enum logic [2:0] {S_IDLE, S_FILL, S_GATE, S_WAIT, S_READ, S_PICK, S_DONE} st_t;

  st_t               st;
  logic              pass;
  logic [AW-1:0]     idx;
  logic [MS_W-1:0]   ms_left, off1_q, off0_q;
  logic [PW-1:0]     pre;
  logic [CW-1:0]     want_q;
  logic [N_CELLS-1:0] fell_hi, rose_lo;

  wire last   = idx == AW'(N_CELLS - 1);
  wire wval   = ~pass;
  wire cand1  = rose_lo[idx] & ~fell_hi[idx];
  wire cand0  = fell_hi[idx] & ~rose_lo[idx];
  wire take1  = cand1 && (sel_one < want_q);
  wire take0  = cand0 && (sel_zero < want_q);
  wire [CW-1:0] nxt1 = sel_one + CW'(take1);
  wire [CW-1:0] nxt0 = sel_zero + CW'(take0);

  assign mem_en    = (st == S_FILL) || (st == S_READ);
  assign mem_we    = (st == S_FILL);
  assign mem_addr  = idx;
  assign mem_wdata = wval;
  assign pg_req    = (st == S_GATE);
  assign done      = (st == S_DONE);
  assign busy      = (st != S_IDLE) && (st != S_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      pass      <= 1'b0;
      idx       <= '0;
      ms_left   <= '0;
      pre       <= '0;
      off1_q    <= '0;
      off0_q    <= '0;
      want_q    <= '0;
      fell_hi   <= '0;
      rose_lo   <= '0;
      mask_one  <= '0;
      mask_zero <= '0;
      sel_one   <= '0;
      sel_zero  <= '0;
      shortfall <= 1'b0;
    end else begin
      case (st)
        S_IDLE, S_DONE: if (start) begin
          off1_q    <= off_one_ms;
          off0_q    <= off_zero_ms;
          want_q    <= want;
          fell_hi   <= '0;
          rose_lo   <= '0;
          mask_one  <= '0;
          mask_zero <= '0;
          sel_one   <= '0;
          sel_zero  <= '0;
          shortfall <= 1'b0;
          pass      <= 1'b0;
          idx       <= '0;
          st        <= S_FILL;
        end
        S_FILL: begin
          if (last) begin
            idx     <= '0;
            ms_left <= pass ? off0_q : off1_q;
            pre     <= '0;
            st      <= S_GATE;
          end else idx <= idx + 1'b1;
        end
        S_GATE: begin
          if (ms_left == '0) st <= S_WAIT;
          else if (pre == PW'(PRESCALE - 1)) begin
            pre     <= '0;
            ms_left <= ms_left - 1'b1;
          end else pre <= pre + 1'b1;
        end
        S_WAIT: if (pg_ack) st <= S_READ;
        S_READ: begin
          if (mem_rdata != wval) begin
            if (!pass) fell_hi[idx] <= 1'b1;
            else       rose_lo[idx] <= 1'b1;
          end
          if (last) begin
            idx <= '0;
            if (!pass) begin
              pass <= 1'b1;
              st   <= S_FILL;
            end else st <= S_PICK;
          end else idx <= idx + 1'b1;
        end
        S_PICK: begin
          if (take1) mask_one[idx]  <= 1'b1;
          if (take0) mask_zero[idx] <= 1'b1;
          sel_one  <= nxt1;
          sel_zero <= nxt0;
          if (last) begin
            shortfall <= (nxt1 < want_q) || (nxt0 < want_q);
            st        <= S_DONE;
          end else idx <= idx + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/remanence_enroll_chk.sv
module remanence_enroll_chk #(
  parameter int N_CELLS = 32,
  localparam int CW = $clog2(N_CELLS + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               mem_en,
  input logic               pg_req,
  input logic               done,
  input logic [N_CELLS-1:0] mask_one,
  input logic [N_CELLS-1:0] mask_zero,
  input logic [CW-1:0]      sel_one,
  input logic [CW-1:0]      sel_zero
);

  AST_MASK_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n) (mask_one & mask_zero) == '0); // R5
  AST_COUNT_ONE: assert property (@(posedge clk) disable iff (!rst_n) done |-> sel_one == CW'($countones(mask_one))); // R7
  AST_COUNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n) done |-> sel_zero == CW'($countones(mask_zero))); // R7
  AST_NO_ACCESS_GATED: assert property (@(posedge clk) disable iff (!rst_n) pg_req |-> !mem_en); // R3
  AST_NO_ACCESS_AT_RESTORE: assert property (@(posedge clk) disable iff (!rst_n) $fell(pg_req) |-> !mem_en); // R3
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) done |-> (!pg_req && !mem_en)); // R7

endmodule

bind remanence_enroll remanence_enroll_chk #(.N_CELLS(N_CELLS)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_en(mem_en), .pg_req(pg_req), .done(done),
  .mask_one(mask_one), .mask_zero(mask_zero), .sel_one(sel_one), .sel_zero(sel_zero)
);

// File: tb/remanence_enroll_test.sv
module remanence_enroll_test;
  localparam int N = 16;
  localparam int P = 4;
  localparam int MW = 6;
  localparam int AW = 4;
  localparam int CW = 5;

  // rows: off_one_ms, off_zero_ms, want, seed
  localparam int VEC [6][4] = '{
    '{3, 5, 4, 1}, '{6, 2, 3, 2}, '{10, 10, 8, 3},
    '{1, 9, 16, 4}, '{7, 7, 2, 5}, '{4, 4, 6, 0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [MW-1:0] off_one_ms = '0, off_zero_ms = '0;
  logic [CW-1:0] want = '0;
  logic mem_en, mem_we, mem_wdata, mem_rdata, pg_req, pg_ack;
  logic [AW-1:0] mem_addr;
  logic done, busy, shortfall;
  logic [N-1:0] mask_one, mask_zero;
  logic [CW-1:0] sel_one, sel_zero;

  int checks = 0;
  int errors = 0;

  int d1 [N];
  int d0 [N];
  logic arr [N];
  int ack_dly = 1;
  int hold = 0;
  logic req_d = 1'b0;
  int g = 0, gi = 0, wc = 0, wbad = 0, rcount = 0, rbad = 0;
  int gl [2];

  always #5 clk = ~clk;

  remanence_enroll #(.N_CELLS(N), .PRESCALE(P), .MS_W(MW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .off_one_ms(off_one_ms),
    .off_zero_ms(off_zero_ms), .want(want), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .pg_req(pg_req), .pg_ack(pg_ack), .done(done), .busy(busy),
    .mask_one(mask_one), .mask_zero(mask_zero), .sel_one(sel_one),
    .sel_zero(sel_zero), .shortfall(shortfall)
  );

  assign mem_rdata = arr[mem_addr];
  assign pg_ack = !pg_req && (hold == 0);

  always @(posedge clk) begin
    if (pg_req) hold <= ack_dly;
    else if (hold != 0) hold <= hold - 1;
    req_d <= pg_req;
    if (start && !busy && rst_n) begin
      g <= 0; gi <= 0; wc <= 0; wbad <= 0; rcount <= 0; rbad <= 0;
    end else begin
      if (pg_req) g <= g + 1;
      if (req_d && !pg_req) begin
        if (gi < 2) gl[gi] <= g;
        gi <= gi + 1;
        g <= 0;
        for (int i = 0; i < N; i++) begin
          if (arr[i] == 1'b1 && d1[i] != 0 && g / P >= d1[i]) arr[i] <= 1'b0;
          if (arr[i] == 1'b0 && d0[i] != 0 && g / P >= d0[i]) arr[i] <= 1'b1;
        end
      end
      if (mem_en && mem_we) begin
        arr[mem_addr] <= mem_wdata;
        if (int'(mem_addr) != wc % N || mem_wdata != (wc < N)) wbad <= wbad + 1;
        wc <= wc + 1;
      end
      if (mem_en && !mem_we) begin
        rcount <= rcount + 1;
        if (!pg_ack) rbad <= rbad + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run(input int o1, input int o0, input int w, input int seed, input int dly, input bit poke);
    int em1, em0, e1, e0, cyc;
    bit fh, fl, sf;
    for (int i = 0; i < N; i++) begin
      d1[i] = (i * 5 + seed * 3) % 9;
      d0[i] = (i * 7 + seed) % 11;
    end
    ack_dly = dly;
    @(negedge clk);
    off_one_ms = MW'(o1);
    off_zero_ms = MW'(o0);
    want = CW'(w);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    off_one_ms = '0;
    off_zero_ms = '0;
    want = '0;
    if (poke) begin
      repeat (N + 3) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    cyc = 0;
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
    chk(done, "R7", "done reached", int'(done), 1);
    em1 = 0; em0 = 0; e1 = 0; e0 = 0;
    for (int i = 0; i < N; i++) begin
      fh = d1[i] != 0 && o1 >= d1[i];
      fl = d0[i] != 0 && o0 >= d0[i];
      if (fl && !fh && e1 < w) begin em1 |= (1 << i); e1++; end
      if (fh && !fl && e0 < w) begin em0 |= (1 << i); e0++; end
      if (fh && fl)
        chk(!mask_one[i] && !mask_zero[i], "R5", "double cell excluded", int'({mask_one[i], mask_zero[i]}), 0);
    end
    sf = (e1 < w) || (e0 < w);
    chk(int'(mask_one) == em1, "R6", "mask_one", int'(mask_one), em1);
    chk(int'(mask_zero) == em0, "R4", "mask_zero", int'(mask_zero), em0);
    chk(int'(sel_one) == e1, "R7", "sel_one", int'(sel_one), e1);
    chk(int'(sel_zero) == e0, "R7", "sel_zero", int'(sel_zero), e0);
    chk(shortfall == sf, "R8", "shortfall", int'(shortfall), int'(sf));
    chk(gl[0] == o1 * P + 1, "R2", "gate after ones fill", gl[0], o1 * P + 1);
    chk(gl[1] == o0 * P + 1, "R2", "gate after zeros fill", gl[1], o0 * P + 1);
    chk(wc == 2 * N && wbad == 0, "R1", "fill order/value errors", wbad, 0);
    chk(rcount == 2 * N, "R3", "read count", rcount, 2 * N);
    chk(rbad == 0, "R3", "reads without power-good", rbad, 0);
    repeat (4) @(negedge clk);
    chk(done && int'(mask_one) == em1, "R7", "done held", int'(done), 1);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      arr[i] = 1'(i % 2);
      d1[i] = 0;
      d0[i] = 0;
    end
    gl[0] = 0;
    gl[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !busy && !pg_req && !mem_en, "R9", "idle outputs after reset",
        int'({done, busy, pg_req, mem_en}), 0);
    chk(mask_one == '0 && mask_zero == '0, "R9", "masks after reset", int'(mask_one | mask_zero), 0);

    for (int r = 0; r < 6; r++)
      run(VEC[r][0], VEC[r][1], VEC[r][2], VEC[r][3], 1 + r % 3, 1'b0);

    run(0, 0, 3, 2, 1, 1'b0);      // R4 R8: no time off, nothing flips
    run(10, 10, 0, 3, 0, 1'b0);    // R6: nothing requested
    run(5, 6, 5, 1, 20, 1'b0);     // R3: slow power-good
    run(4, 8, 4, 2, 2, 1'b1);      // R7: start while busy ignored

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule